// File: doc/BRIEF.md
# IEEE-488 Interrupt Status Unit

This block gathers event indications from an IEEE-488 bus controller into two 8-bit status registers. From these it drives a single level interrupt request toward the host. Bus-side logic supplies one-cycle event strobes and level-change strobes for the receive and transmit data registers. The host side supplies read and write strobes, a register select, write data, a global interrupt enable, a disable-all flag and a software-reset pulse.

Each status register has a write-only mask register. The mask uses the same bit positions as its status register. In register 0, bits 7 and 6 are summary bits. They show whether register 0 or register 1 holds an event whose mask bit is set. The interrupt request is the OR of the two summaries, gated by the global enable and the disable-all flag. The disable-all flag blocks the request but leaves the recorded events in place.

Status bits clear when the host reads their register. The exception is the two data-flow bits in register 0, which follow the data registers: the byte-in bit clears when the receive data is read, and the byte-out bit clears when the transmit data is written.

Top module: `gpib_irq_status`

## Requirements
- R1: The read value of register 0 is {8'h00, sum0, sum1, byte_in, byte_out, ev0[3:0]}. The event strobe vector ev0_i maps to bits 3..0 in this order, bit 3 first: end-of-message, serial-poll-active, remote/local change, address change. The read value of register 1 is {8'h00, ev1[7:0]}, with bits 7..0 in this order: trigger, handshake error, unknown command, secondary address, device clear, my address, service request, interface clear. Bits 15..8 of both read values are always zero.
- R2: A strobe on any bit of ev0_i or ev1_i sets the matching status bit in the following cycle. A host read (host_rd_i high) with host_sel_i=0 clears bits 3..0 of register 0 in the following cycle. A host read with host_sel_i=1 clears all bits of register 1 in the following cycle.
- R3: An event strobe that arrives in the same cycle as a read of its register leaves its bit set.
- R4: byte_in is set by rx_full_i and cleared only by rx_read_i. A status read of register 0 does not clear it.
- R5: byte_out is cleared by tx_write_i and set by tx_ready_i or talk_enter_i. A status read of register 0 does not clear it.
- R6: A host write (host_wr_i high) loads host_wdata_i[7:0] into mask 0 when host_sel_i=0 and into mask 1 when host_sel_i=1. Mask bits 7..6 of mask 0 have no effect.
- R7: sum0 is 1 when any of register 0 bits 5..0 is set together with its mask bit. sum1 is 1 when any bit of register 1 is set together with its mask bit. Both follow the status and mask state in the same cycle.
- R8: irq_o equals irq_en_i AND NOT dis_all_i AND (sum0 OR sum1). It is a level that responds within the same cycle to the enable and disable-all inputs.
- R9: While dis_all_i is high, irq_o stays low, and events are still recorded in the status registers.
- R10: sw_rst_i clears both status registers in the following cycle, and it takes priority over simultaneous events. The mask registers keep their contents.
- R11: For byte_in and byte_out, a set condition wins over a clear condition that occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ev0_i | input | 4 | Event strobes for register 0, bits 3..0 |
| ev1_i | input | 8 | Event strobes for register 1 |
| rx_full_i | input | 1 | Receive data register filled |
| rx_read_i | input | 1 | Host read of receive data register |
| tx_ready_i | input | 1 | Transmit data register can take a byte |
| tx_write_i | input | 1 | Host write of transmit data register |
| talk_enter_i | input | 1 | Talker mode entered |
| host_rd_i | input | 1 | Status register read strobe |
| host_wr_i | input | 1 | Mask register write strobe |
| host_sel_i | input | 1 | Register select, 0 or 1 |
| host_wdata_i | input | 8 | Mask write data |
| irq_en_i | input | 1 | Global interrupt enable |
| dis_all_i | input | 1 | Disable all interrupts |
| sw_rst_i | input | 1 | Software reset pulse |
| stat0_o | output | 16 | Register 0 read value |
| stat1_o | output | 16 | Register 1 read value |
| irq_o | output | 1 | Interrupt request level |

## Verification
The bench builds the block with its default parameters: four register 0 event lines, eight register 1 event lines and 16-bit read words. With these values every bit position and both summaries can be reached, so each field placement in R1 can be checked directly. The stimulus deliberately drives set and clear conditions in the same cycle. It also pairs a software reset with incoming events, masks only part of a register, and toggles the disable-all and enable inputs while events are pending. These cases exercise the priorities in R3, R10 and R11 and the same-cycle gating in R8.

// File: rtl/gpib_irq_pkg.sv
package gpib_irq_pkg;
  localparam int unsigned RD_W   = 16;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned EV0_W  = 4;
  localparam int unsigned FLOW_W = 2;
  localparam int unsigned LO0_W  = EV0_W + FLOW_W;
  localparam int unsigned PAD_W  = RD_W - REG_W;
  localparam int unsigned SUMPAD = REG_W - LO0_W - 2;

  localparam int unsigned BIT_BI = EV0_W + 1;
  localparam int unsigned BIT_BO = EV0_W;

  typedef enum logic {SEL_R0 = 1'b0, SEL_R1 = 1'b1} reg_sel_e;
endpackage

// File: rtl/gpib_stat_reg.sv
module gpib_stat_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[b] <= 1'b0;
      else if (srst_i)    q_o[b] <= 1'b0;
      else if (set_i[b])  q_o[b] <= 1'b1;  // set wins over clear
      else if (clr_i[b])  q_o[b] <= 1'b0;
    end
  end

  // R2 R3 R11
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srst_i |=> ((q_o & $past(set_i)) == $past(set_i)));
  // R2 R4 R5
  clear_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srst_i |=> ((q_o & $past(clr_i & ~set_i)) == '0));
  // R10
  srst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (q_o == '0));
endmodule

// File: rtl/gpib_mask_reg.sv
module gpib_mask_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end

  // R6 R10
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/gpib_irq_gate.sv
module gpib_irq_gate #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pend0_i,
  input  logic [W-1:0] mask0_i,
  input  logic [W-1:0] pend1_i,
  input  logic [W-1:0] mask1_i,
  input  logic         en_i,
  input  logic         dis_i,
  output logic         sum0_o,
  output logic         sum1_o,
  output logic         irq_o
);
  assign sum0_o = |(pend0_i & mask0_i);
  assign sum1_o = |(pend1_i & mask1_i);
  assign irq_o  = en_i & ~dis_i & (sum0_o | sum1_o);

  // R9
  dis_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |-> !irq_o);
  // R8
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_i && (pend0_i != '0 || pend1_i != '0)));
endmodule

// File: rtl/gpib_irq_status.sv
module gpib_irq_status
  import gpib_irq_pkg::*;
#(
  parameter int unsigned EV_W  = EV0_W,
  parameter int unsigned R_W   = REG_W,
  parameter int unsigned OUT_W = RD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EV_W-1:0]  ev0_i,
  input  logic [R_W-1:0]   ev1_i,
  input  logic             rx_full_i,
  input  logic             rx_read_i,
  input  logic             tx_ready_i,
  input  logic             tx_write_i,
  input  logic             talk_enter_i,
  input  logic             host_rd_i,
  input  logic             host_wr_i,
  input  logic             host_sel_i,
  input  logic [R_W-1:0]   host_wdata_i,
  input  logic             irq_en_i,
  input  logic             dis_all_i,
  input  logic             sw_rst_i,
  output logic [OUT_W-1:0] stat0_o,
  output logic [OUT_W-1:0] stat1_o,
  output logic             irq_o
);
  localparam int unsigned L0W = EV_W + 2;
  localparam int unsigned PW  = OUT_W - R_W;
  localparam int unsigned ZW  = R_W - L0W - 2;

  logic rd0, rd1, wr0, wr1;
  assign rd0 = host_rd_i & (host_sel_i == SEL_R0);
  assign rd1 = host_rd_i & (host_sel_i == SEL_R1);
  assign wr0 = host_wr_i & (host_sel_i == SEL_R0);
  assign wr1 = host_wr_i & (host_sel_i == SEL_R1);

  logic [L0W-1:0] set0, clr0, s0;
  logic [R_W-1:0] s1, m0, m1, pend0;
  logic           sum0, sum1;

  // byte-in / byte-out follow data-register access, not status reads
  assign set0 = {rx_full_i, tx_ready_i | talk_enter_i, ev0_i};
  assign clr0 = {rx_read_i, tx_write_i, {EV_W{rd0}}};

  gpib_stat_reg #(.W(L0W)) u_stat0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(sw_rst_i),
    .set_i(set0), .clr_i(clr0), .q_o(s0));

  gpib_stat_reg #(.W(R_W)) u_stat1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(sw_rst_i),
    .set_i(ev1_i), .clr_i({R_W{rd1}}), .q_o(s1));

  gpib_mask_reg #(.W(R_W)) u_mask0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr0),
    .wdata_i(host_wdata_i), .q_o(m0));

  gpib_mask_reg #(.W(R_W)) u_mask1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr1),
    .wdata_i(host_wdata_i), .q_o(m1));

  // summary bit positions carry no pending state
  assign pend0 = {{(R_W-L0W){1'b0}}, s0};

  gpib_irq_gate #(.W(R_W)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pend0_i(pend0), .mask0_i(m0), .pend1_i(s1), .mask1_i(m1),
    .en_i(irq_en_i), .dis_i(dis_all_i),
    .sum0_o(sum0), .sum1_o(sum1), .irq_o(irq_o));

  if (ZW > 0) begin : g_gap
    assign stat0_o = {{PW{1'b0}}, sum0, sum1, {ZW{1'b0}}, s0};
  end else begin : g_nogap
    assign stat0_o = {{PW{1'b0}}, sum0, sum1, s0};
  end
  assign stat1_o = {{PW{1'b0}}, s1};

  // R4
  bi_status_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat0_o[EV_W+1] && rd0 && !rx_read_i && !sw_rst_i) |=> stat0_o[EV_W+1]);
  // R5
  bo_status_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat0_o[EV_W] && rd0 && !tx_write_i && !sw_rst_i) |=> stat0_o[EV_W]);
endmodule

// File: tb/gpib_irq_status_bench.sv
module gpib_irq_status_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]  ev0 = '0;
  logic [7:0]  ev1 = '0, wdata = '0;
  logic rx_full = 0, rx_read = 0, tx_ready = 0, tx_write = 0, talk = 0;
  logic host_rd = 0, host_wr = 0, sel = 0, irq_en = 0, dis_all = 0, sw_rst = 0;
  logic [15:0] stat0, stat1;
  logic irq;

  gpib_irq_status u_gpib_irq_status (
    .clk_i(clk), .rst_ni(rst_n), .ev0_i(ev0), .ev1_i(ev1),
    .rx_full_i(rx_full), .rx_read_i(rx_read), .tx_ready_i(tx_ready),
    .tx_write_i(tx_write), .talk_enter_i(talk), .host_rd_i(host_rd),
    .host_wr_i(host_wr), .host_sel_i(sel), .host_wdata_i(wdata),
    .irq_en_i(irq_en), .dis_all_i(dis_all), .sw_rst_i(sw_rst),
    .stat0_o(stat0), .stat1_o(stat1), .irq_o(irq));

  typedef struct {
    logic [15:0] s0;
    logic [15:0] s1;
    logic        irq;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0;
  logic [5:0] m_s0 = '0, m_m0 = '0;
  logic [7:0] m_s1 = '0, m_m1 = '0;

  task automatic cmp(input exp_t e);
    checks++;
    if (stat0 !== e.s0 || stat1 !== e.s1 || irq !== e.irq) begin
      errors++;
      $display("FAIL %s: got s0=%h s1=%h irq=%b exp s0=%h s1=%h irq=%b",
               e.tag, stat0, stat1, irq, e.s0, e.s1, e.irq);
    end
  endtask

  // driver: update model at the edge, push expectation, clear strobes
  task automatic cyc(input string tag);
    exp_t e;
    logic i0, i1;
    @(posedge clk);
    if (sw_rst) begin
      m_s0 = '0; m_s1 = '0;
    end else begin
      m_s0[3:0] = (m_s0[3:0] & ~{4{host_rd && !sel}}) | ev0;
      m_s0[5]   = (m_s0[5] & ~rx_read) | rx_full;
      m_s0[4]   = (m_s0[4] & ~tx_write) | tx_ready | talk;
      m_s1      = (m_s1 & ~{8{host_rd && sel}}) | ev1;
    end
    if (host_wr) begin
      if (sel) m_m1 = wdata; else m_m0 = wdata[5:0];
    end
    i0 = |(m_s0 & m_m0);
    i1 = |(m_s1 & m_m1);
    e.s0  = {8'h00, i0, i1, m_s0};
    e.s1  = {8'h00, m_s1};
    e.irq = irq_en & ~dis_all & (i0 | i1);
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    ev0 = '0; ev1 = '0; rx_full = 0; rx_read = 0; tx_ready = 0;
    tx_write = 0; talk = 0; host_rd = 0; host_wr = 0; sw_rst = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0) cmp(sb.pop_front());
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got hung exp done");
    finish_run();
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    r.s0 = '0; r.s1 = '0; r.irq = 0; r.tag = "R1 reset";
    cmp(r);

    // R1 layout with masks still zero
    ev0 = 4'b1000; cyc("R1 end bit 3");
    host_rd = 1; sel = 0; cyc("R2 read0 clears");
    // R6 masks
    host_wr = 1; sel = 0; wdata = 8'hFF; cyc("R6 mask0");
    host_wr = 1; sel = 1; wdata = 8'hFF; cyc("R6 mask1");
    ev0 = 4'b1010; cyc("R2 R7 ev0 set");
    irq_en = 1; cyc("R8 enable");
    dis_all = 1; cyc("R9 blocked");
    ev1 = 8'h81; cyc("R9 events recorded");
    dis_all = 0; cyc("R8 unblocked");
    host_rd = 1; sel = 0; cyc("R2 read0");
    host_rd = 1; sel = 1; ev1 = 8'h04; cyc("R3 event on read1");
    host_rd = 1; sel = 1; cyc("R2 read1");
    host_rd = 1; sel = 0; ev0 = 4'b0001; cyc("R3 event on read0");
    host_rd = 1; sel = 0; cyc("R2 clear again");
    rx_full = 1; cyc("R4 byte_in set");
    host_rd = 1; sel = 0; cyc("R4 status read keeps");
    rx_read = 1; cyc("R4 data read clears");
    rx_read = 1; rx_full = 1; cyc("R11 byte_in set wins");
    rx_read = 1; cyc("R4 clear");
    talk = 1; cyc("R5 talker entry");
    host_rd = 1; sel = 0; cyc("R5 status read keeps");
    tx_write = 1; cyc("R5 write clears");
    tx_ready = 1; cyc("R5 ready sets");
    tx_write = 1; tx_ready = 1; cyc("R11 byte_out set wins");
    host_wr = 1; sel = 0; wdata = 8'hC0; cyc("R6 R7 upper mask bits inert");
    host_wr = 1; sel = 1; wdata = 8'h01; cyc("R6 mask1 partial");
    ev1 = 8'h02; cyc("R7 unmasked event");
    ev1 = 8'h01; cyc("R7 masked event");
    irq_en = 0; cyc("R8 disabled");
    irq_en = 1; sw_rst = 1; ev0 = 4'hF; ev1 = 8'hFF; rx_full = 1; cyc("R10 reset wins");
    ev1 = 8'h01; cyc("R10 mask kept");
    dis_all = 1; cyc("R9 blocked again");
    dis_all = 0; host_rd = 1; sel = 1; cyc("R2 final read");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule